// File: doc/BRIEF.md
# NAND Flash Command Interface Controller

This block is the device-side front end of a small-page, byte-wide NAND memory. The host drives an 8-bit bus together with strobes that select a command byte, an address byte or a data byte. Each byte is taken on the rising edge of the write strobe. The block decodes the command codes and counts the address cycles. It starts internal operations, reports them on an active-low ready/busy output, and keeps an 8-bit status byte that the host can read back.

All strobes are sampled in a system clock domain, and edges are found by comparing each strobe with its value one clock earlier. The array and its timing are not modelled. Each operation keeps the device busy for a parameter number of clock cycles. The result of a program or erase is set by a test hook input. A read from the array area returns FFh, which is the value of an erased cell. The captured address and the selected read area are presented on outputs for the array side.

Top module: `nand_cmd_if`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` while `ce_n` is low. It is a command when `cle`=1, `ale`=0 and `re_n`=1. It is an address when `ale`=1 and `cle`=0. It is data when both `cle` and `ale` are 0. A byte written while `ce_n` is high has no effect.
- R2: Command 00h, 01h or 50h, followed by four address bytes, makes `rb_n` low for exactly T_READ clocks. `arr_addr` then holds the bytes with the first one in bits 7:0. `arr_area` is 0 for 00h, 1 for 01h and 2 for 50h. Array reads return FFh.
- R3: The sequence 80h, four address bytes, at least one data byte and then 10h makes `rb_n` low for exactly T_PROG clocks. If 10h arrives before any data byte, no operation starts.
- R4: The sequence 60h, three address bytes and then D0h makes `rb_n` low for exactly T_ERASE clocks. The three bytes go to `arr_addr[31:8]` and `arr_addr[7:0]` reads 0.
- R5: While `rb_n` is low, only 70h and FFh are acted on. Every other command is ignored.
- R6: The status byte is {WP, ready, ready, 0000, fail}. Bit 7 is 1 when not protected, bits 6 and 5 are 1 when ready, and bit 0 is 1 on failure.
- R7: After 70h, every read returns the status byte until another command changes the output mode. The status byte follows the busy state without a new 70h.
- R8: While `wp_n` is low, program, erase and copy-back do not start. `wp_n` is used live, not latched, so status bit 7 follows it.
- R9: FFh starts a busy period of exactly T_RESET clocks, and aborts any operation in progress. Afterwards the status byte is E0h when `wp_n` is high, and reads return array data.
- R10: 90h followed by address 00h makes successive reads return ADh, then 76h, then 00h. 90h with any other address leaves the output mode unchanged.
- R11: 8Ah followed by four address bytes starts a program of T_PROG clocks without any 10h. A 10h sent during that busy period changes nothing.
- R12: The `force_fail` level taken when a program, erase or copy-back starts sets status bit 0 when the operation ends. The next program or erase start clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks the bus byte as a command |
| ale | input | 1 | Marks the bus byte as an address |
| we_n | input | 1 | Write strobe; byte taken on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte from host |
| force_fail | input | 1 | Test hook: next program/erase reports failure |
| io_out | output | 8 | Bus byte to host |
| io_oe | output | 1 | Output enable for `io_out` |
| rb_n | output | 1 | Ready (1) / busy (0) |
| arr_addr | output | 32 | Captured address for the array side |
| arr_area | output | 2 | Read area: 0 first half, 1 second half, 2 spare |

## Verification
The decoder is driven with complete sequences for read, program, erase, copy-back, ID and reset, and with broken ones. The broken sequences are a confirm with no data, a write with select released, a non-zero ID address, and commands sent while busy. The complete sequences show that each code is decoded, because each operation has its own busy length. The broken ones show that a missing or extra step leaves no trace on `rb_n` or in the read-back byte. Status reads are taken mid-operation, after failure injection, with protect asserted and after a reset that aborts an erase. This separates the live busy and protect bits from the latched fail bit.

// File: rtl/nand_cif_pkg.sv
package nand_cif_pkg;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} out_mode_e;
  typedef enum logic [1:0] {TM_READ, TM_PROG, TM_ERASE, TM_RESET} tmr_sel_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DLOAD, ST_ECONF, ST_BUSY} cif_state_e;
  typedef enum logic [2:0] {OP_READ, OP_PROG, OP_ERASE, OP_COPY, OP_ID, OP_RST} cif_op_e;

  localparam logic [7:0] CMD_READ_A      = 8'h00;
  localparam logic [7:0] CMD_READ_B      = 8'h01;
  localparam logic [7:0] CMD_READ_SP     = 8'h50;
  localparam logic [7:0] CMD_ID          = 8'h90;
  localparam logic [7:0] CMD_RST         = 8'hFF;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_COPY_DEST   = 8'h8A;

  localparam logic [7:0] ID_MAKER  = 8'hAD;
  localparam logic [7:0] ID_DEVICE = 8'h76;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic [DW-1:0] io_in,
  output logic          ev_cmd,
  output logic          ev_addr,
  output logic          ev_data,
  output logic [DW-1:0] ev_byte,
  output logic          re_rise
);
  logic we_q, re_q;
  logic cmd_q, addr_q, data_q;
  logic [DW-1:0] byte_q;
  logic we_rise;
  logic cmd_n, addr_n, data_n;
  logic [DW-1:0] byte_n;

  assign we_rise = we_n & ~we_q;

  always_comb begin
    cmd_n  = we_rise & ~ce_n &  cle & ~ale & re_n;
    addr_n = we_rise & ~ce_n & ~cle &  ale;
    data_n = we_rise & ~ce_n & ~cle & ~ale;
    byte_n = byte_q;
    if (we_rise) byte_n = io_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      re_q   <= 1'b1;
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
      data_q <= 1'b0;
      byte_q <= '0;
    end else begin
      we_q   <= we_n;
      re_q   <= re_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      data_q <= data_n;
      byte_q <= byte_n;
    end
  end

  assign ev_cmd  = cmd_q;
  assign ev_addr = addr_q;
  assign ev_data = data_q;
  assign ev_byte = byte_q;
  assign re_rise = re_n & ~re_q & ~ce_n;

  // R1
  ev_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd | ev_addr | ev_data) |-> $past(!ce_n));
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer
  import nand_cif_pkg::*;
#(
  parameter int unsigned T_READ  = 1200,
  parameter int unsigned T_PROG  = 10000,
  parameter int unsigned T_ERASE = 75000,
  parameter int unsigned T_RESET = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tmr_sel_e sel,
  output logic     busy,
  output logic     done
);
  localparam int unsigned T_AB  = (T_READ > T_PROG) ? T_READ : T_PROG;
  localparam int unsigned T_CD  = (T_ERASE > T_RESET) ? T_ERASE : T_RESET;
  localparam int unsigned T_MAX = (T_AB > T_CD) ? T_AB : T_CD;
  localparam int CW = $clog2(T_MAX + 1);

  logic [CW-1:0] cnt, cnt_n, len;
  logic busy_n;

  always_comb begin
    case (sel)
      TM_READ:  len = CW'(T_READ - 1);
      TM_PROG:  len = CW'(T_PROG - 1);
      TM_ERASE: len = CW'(T_ERASE - 1);
      default:  len = CW'(T_RESET - 1);
    endcase
  end

  always_comb begin
    cnt_n  = cnt;
    busy_n = busy;
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = len;
    end else if (busy) begin
      if (cnt == '0) busy_n = 1'b0;
      else           cnt_n  = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      busy <= busy_n;
    end
  end

  assign done = busy & (cnt == '0);

  // R2
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_cif_pkg::*;
#(
  parameter int ADDR_CYC = 4,
  localparam int ADDR_W  = 8 * ADDR_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmd,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic [7:0]        ev_byte,
  input  logic              wp_n,
  input  logic              force_fail,
  input  logic              tmr_done,
  output logic              tmr_load,
  output tmr_sel_e          tmr_sel,
  output out_mode_e         mode,
  output logic              id_clr,
  output logic              fail,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [1:0]        arr_area
);
  localparam int CNT_W = $clog2(ADDR_CYC + 1);
  localparam logic [CNT_W-1:0] NEED_FULL  = CNT_W'(ADDR_CYC);
  localparam logic [CNT_W-1:0] NEED_ERASE = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] NEED_ID    = CNT_W'(1);

  cif_state_e st, st_n;
  cif_op_e    op, op_n;
  out_mode_e  mode_n;
  logic [CNT_W-1:0]  cnt, cnt_n, idx, need;
  logic [ADDR_W-1:0] addr_n;
  logic [1:0] area_n;
  logic seen, seen_n, fail_n, arm, arm_n;
  logic start, rst_req;
  tmr_sel_e start_sel;

  always_comb begin
    st_n = st; op_n = op; cnt_n = cnt; addr_n = arr_addr; area_n = arr_area;
    seen_n = seen; fail_n = fail; arm_n = arm; mode_n = mode;
    tmr_load = 1'b0; tmr_sel = TM_READ; id_clr = 1'b0;
    start = 1'b0; start_sel = TM_READ; rst_req = 1'b0;
    idx = (op == OP_ERASE) ? cnt + 1'b1 : cnt;
    case (op)
      OP_ERASE: need = NEED_ERASE;
      OP_ID:    need = NEED_ID;
      default:  need = NEED_FULL;
    endcase

    if (st == ST_BUSY && tmr_done) begin
      st_n = ST_IDLE;
      if (op == OP_PROG || op == OP_ERASE || op == OP_COPY) fail_n = arm;
    end

    if (ev_cmd) begin
      if (st == ST_BUSY) begin
        if (ev_byte == CMD_STATUS)   mode_n  = OUT_STATUS;
        else if (ev_byte == CMD_RST) rst_req = 1'b1;
      end else begin
        case (ev_byte)
          CMD_READ_A, CMD_READ_B, CMD_READ_SP: begin
            op_n = OP_READ; st_n = ST_ADDR; cnt_n = '0; addr_n = '0;
            mode_n = OUT_ARRAY;
            area_n = (ev_byte == CMD_READ_SP) ? 2'd2 : {1'b0, ev_byte[0]};
          end
          CMD_PROG_SETUP: begin
            op_n = OP_PROG; st_n = ST_ADDR; cnt_n = '0; addr_n = '0; seen_n = 1'b0;
          end
          CMD_COPY_DEST: begin
            op_n = OP_COPY; st_n = ST_ADDR; cnt_n = '0; addr_n = '0;
          end
          CMD_ERASE_SETUP: begin
            op_n = OP_ERASE; st_n = ST_ADDR; cnt_n = '0; addr_n = '0;
          end
          CMD_ID: begin
            op_n = OP_ID; st_n = ST_ADDR; cnt_n = '0;
          end
          CMD_STATUS: mode_n  = OUT_STATUS;
          CMD_RST:    rst_req = 1'b1;
          CMD_PROG_GO: begin
            st_n = ST_IDLE;
            if (st == ST_DLOAD && seen && wp_n) begin
              start = 1'b1; start_sel = TM_PROG;
            end
          end
          CMD_ERASE_GO: begin
            st_n = ST_IDLE;
            if (st == ST_ECONF && wp_n) begin
              start = 1'b1; start_sel = TM_ERASE;
            end
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end else if (ev_addr && st == ST_ADDR) begin
      for (int b = 0; b < ADDR_CYC; b++) begin
        if (idx == CNT_W'(b)) addr_n[8*b +: 8] = ev_byte;
      end
      cnt_n = cnt + 1'b1;
      if (cnt_n == need) begin
        case (op)
          OP_READ: begin start = 1'b1; start_sel = TM_READ; end
          OP_PROG: begin st_n = ST_DLOAD; seen_n = 1'b0; end
          OP_COPY: begin
            st_n = ST_IDLE;
            if (wp_n) begin start = 1'b1; start_sel = TM_PROG; end
          end
          OP_ERASE: st_n = ST_ECONF;
          OP_ID: begin
            st_n = ST_IDLE;
            if (ev_byte == 8'h00) begin mode_n = OUT_ID; id_clr = 1'b1; end
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end else if (ev_data && st == ST_DLOAD) begin
      seen_n = 1'b1;
    end

    if (rst_req) begin
      st_n = ST_BUSY; op_n = OP_RST; tmr_load = 1'b1; tmr_sel = TM_RESET;
      fail_n = 1'b0; mode_n = OUT_ARRAY; cnt_n = '0; seen_n = 1'b0;
    end else if (start) begin
      st_n = ST_BUSY; tmr_load = 1'b1; tmr_sel = start_sel;
      if (start_sel != TM_READ) begin
        fail_n = 1'b0; arm_n = force_fail;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op <= OP_READ; cnt <= '0; arr_addr <= '0; arr_area <= 2'd0;
      seen <= 1'b0; fail <= 1'b0; arm <= 1'b0; mode <= OUT_ARRAY;
    end else begin
      st <= st_n; op <= op_n; cnt <= cnt_n; arr_addr <= addr_n; arr_area <= area_n;
      seen <= seen_n; fail <= fail_n; arm <= arm_n; mode <= mode_n;
    end
  end

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && ev_cmd && ev_byte != CMD_STATUS && ev_byte != CMD_RST && !tmr_done)
    |=> (st == ST_BUSY && $stable(mode)));

  // R3
  no_data_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DLOAD && !seen && ev_cmd && ev_byte == CMD_PROG_GO) |=> (st == ST_IDLE));

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && st != ST_BUSY) |=> (st != ST_BUSY || op == OP_READ || op == OP_RST));
endmodule

// File: rtl/nand_out_mux.sv
module nand_out_mux
  import nand_cif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  out_mode_e  mode,
  input  logic       fail,
  input  logic       busy,
  input  logic       wp_n,
  input  logic       ce_n,
  input  logic       re_n,
  input  logic       re_rise,
  input  logic       id_clr,
  output logic [7:0] io_out,
  output logic       io_oe
);
  logic [1:0] id_ptr, id_ptr_n;
  logic [7:0] status;

  assign status = {wp_n, ~busy, ~busy, 4'b0000, fail};

  always_comb begin
    id_ptr_n = id_ptr;
    if (id_clr) id_ptr_n = 2'd0;
    else if (re_rise && mode == OUT_ID && id_ptr != 2'd2) id_ptr_n = id_ptr + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_ptr <= 2'd0;
    else        id_ptr <= id_ptr_n;
  end

  always_comb begin
    case (mode)
      OUT_STATUS: io_out = status;
      OUT_ID: begin
        case (id_ptr)
          2'd0:    io_out = ID_MAKER;
          2'd1:    io_out = ID_DEVICE;
          default: io_out = 8'h00;
        endcase
      end
      default: io_out = ERASED_BYTE;
    endcase
  end

  assign io_oe = ~ce_n & ~re_n;

  // R10
  id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_ID && io_oe) |-> (io_out == ID_MAKER || io_out == ID_DEVICE || io_out == 8'h00));

  // R6
  status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_STATUS) |-> (io_out[4:1] == 4'b0000 && io_out[5] == io_out[6] && io_out[7] == wp_n));
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_cif_pkg::*;
#(
  parameter int unsigned T_READ  = 1200,
  parameter int unsigned T_PROG  = 10000,
  parameter int unsigned T_ERASE = 75000,
  parameter int unsigned T_RESET = 250,
  parameter int ADDR_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    cle,
  input  logic                    ale,
  input  logic                    we_n,
  input  logic                    re_n,
  input  logic                    wp_n,
  input  logic [7:0]              io_in,
  input  logic                    force_fail,
  output logic [7:0]              io_out,
  output logic                    io_oe,
  output logic                    rb_n,
  output logic [8*ADDR_CYC-1:0]   arr_addr,
  output logic [1:0]              arr_area
);
  logic ev_cmd, ev_addr, ev_data, re_rise;
  logic [7:0] ev_byte;
  logic tmr_load, tmr_done, busy, id_clr, fail;
  tmr_sel_e tmr_sel;
  out_mode_e mode;

  nand_bus_sampler #(.DW(8)) u_sampler (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .ev_cmd(ev_cmd), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_byte(ev_byte), .re_rise(re_rise)
  );

  nand_cmd_ctrl #(.ADDR_CYC(ADDR_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_byte(ev_byte), .wp_n(wp_n), .force_fail(force_fail), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_sel(tmr_sel), .mode(mode), .id_clr(id_clr),
    .fail(fail), .arr_addr(arr_addr), .arr_area(arr_area)
  );

  nand_busy_timer #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RESET(T_RESET)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel(tmr_sel), .busy(busy), .done(tmr_done)
  );

  nand_out_mux u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fail(fail), .busy(busy), .wp_n(wp_n),
    .ce_n(ce_n), .re_n(re_n), .re_rise(re_rise), .id_clr(id_clr),
    .io_out(io_out), .io_oe(io_oe)
  );

  assign rb_n = ~busy;

  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> $past(ev_cmd | ev_addr));
endmodule

// File: tb/tb_nand_cmd_if.sv
module tb_nand_cmd_if;
  localparam int CLK_PERIOD = 10;
  localparam int TR = 20, TP = 40, TE = 60, TS = 10;

  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, wp_n, force_fail;
  logic [7:0] io_in, io_out;
  logic io_oe, rb_n;
  logic [31:0] arr_addr;
  logic [1:0] arr_area;

  int compared = 0, mismatched = 0;
  logic [7:0] q_exp[$];
  string q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_if #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .T_RESET(TS), .ADDR_CYC(4)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .force_fail(force_fail),
    .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .arr_addr(arr_addr), .arr_area(arr_area)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int kind, input logic [7:0] b, input logic ce);
    @(negedge clk);
    ce_n = ce; cle = (kind == 0); ale = (kind == 1); io_in = b; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); bus_wr(0, b, 1'b0); endtask
  task automatic adr(input logic [7:0] b); bus_wr(1, b, 1'b0); endtask
  task automatic dat(input logic [7:0] b); bus_wr(2, b, 1'b0); endtask

  task automatic adr4(input logic [31:0] a);
    for (int i = 0; i < 4; i++) adr(a[8*i +: 8]);
  endtask

  // driver: push expected item, then pulse the read strobe
  task automatic rd(input logic [7:0] exp, input string req);
    q_exp.push_back(exp);
    q_req.push_back(req);
    @(negedge clk); re_n = 1'b0;
    repeat (4) @(negedge clk);
    re_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops and compares while the read strobe is low
  initial begin
    forever begin
      @(negedge re_n);
      repeat (2) @(negedge clk);
      compared++;
      if (q_exp.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: actual %h expected none", io_out);
      end else begin
        logic [7:0] e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        if (io_out !== e || io_oe !== 1'b1) begin
          mismatched++;
          $display("FAIL %s: actual %h/oe%b expected %h/oe1", r, io_out, io_oe, e);
        end
      end
    end
  end

  task automatic measure_busy(input int exp, input string req);
    int n = 0;
    for (int k = 0; k < 10; k++) begin
      if (rb_n == 1'b0) break;
      @(negedge clk);
    end
    while (rb_n == 1'b0 && n < 100000) begin
      n++;
      @(negedge clk);
    end
    check(req, n, exp);
  endtask

  task automatic no_busy(input string req);
    int n = 0;
    repeat (12) begin
      if (rb_n == 1'b0) n++;
      @(negedge clk);
    end
    check(req, n, 0);
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (rb_n == 1'b0 && k < 100000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
    wp_n = 1'b1; io_in = 8'h00; force_fail = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    // reset state
    check("R9 reset rb_n", {31'd0, rb_n}, 32'd1);
    check("R9 reset io_oe", {31'd0, io_oe}, 32'd0);
    check("R2 reset arr_addr", arr_addr, 32'd0);

    // R1: command with chip deselected has no effect
    bus_wr(0, 8'h70, 1'b1);
    rd(8'hFF, "R1 deselected write ignored");

    // R2: reads with area selection
    cmd(8'h00); adr4(32'h01332211);
    measure_busy(TR, "R2 read busy length");
    check("R2 address capture", arr_addr, 32'h01332211);
    check("R2 area 00h", {30'd0, arr_area}, 32'd0);
    rd(8'hFF, "R2 array data");
    cmd(8'h01); adr4(32'h00000005);
    measure_busy(TR, "R2 read 01h busy");
    check("R2 area 01h", {30'd0, arr_area}, 32'd1);
    cmd(8'h50); adr4(32'h00000003);
    measure_busy(TR, "R2 read 50h busy");
    check("R2 area 50h", {30'd0, arr_area}, 32'd2);

    // R6 R7: status persists
    cmd(8'h70);
    rd(8'hE0, "R6 idle status");
    rd(8'hE0, "R7 status repeat");

    // R3: confirm without data, then proper program
    cmd(8'h80); adr4(32'h00010200);
    cmd(8'h10);
    no_busy("R3 confirm without data");
    cmd(8'h80); adr4(32'h00010200); dat(8'h5A); dat(8'hA5); cmd(8'h10);
    measure_busy(TP, "R3 program busy length");
    rd(8'hE0, "R7 status after program");

    // R12: injected failure, then cleared by erase
    force_fail = 1'b1;
    cmd(8'h80); adr4(32'h00000000); dat(8'h11); cmd(8'h10);
    force_fail = 1'b0;
    measure_busy(TP, "R12 failing program busy");
    cmd(8'h70);
    rd(8'hE1, "R12 fail bit set");
    cmd(8'h60); adr(8'h45); adr(8'h67); adr(8'h01);
    check("R4 erase row address", arr_addr, 32'h01674500);
    cmd(8'hD0);
    measure_busy(TE, "R4 erase busy length");
    rd(8'hE0, "R12 fail bit cleared");

    // R5: commands ignored while busy
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0);
    cmd(8'h70);
    rd(8'h80, "R6 busy status");
    cmd(8'h00);
    rd(8'h80, "R5 read command ignored while busy");
    wait_ready(k);
    rd(8'hE0, "R7 status follows ready");

    // R8: write protect
    wp_n = 1'b0;
    cmd(8'h80); adr4(32'h00000100); dat(8'h22); cmd(8'h10);
    no_busy("R8 program blocked");
    cmd(8'h60); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'hD0);
    no_busy("R8 erase blocked");
    cmd(8'h8A); adr4(32'h00000200);
    no_busy("R8 copy-back blocked");
    cmd(8'h70);
    rd(8'h60, "R8 protected status");
    wp_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'hE0, "R8 protect bit live");

    // R9: reset from idle, and reset aborting erase
    cmd(8'hFF);
    measure_busy(TS, "R9 reset busy length");
    cmd(8'h60); adr(8'h09); adr(8'h00); adr(8'h00); cmd(8'hD0);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    wait_ready(k);
    check("R9 reset aborts erase", {31'd0, (k <= TS + 2) && (k > 0)}, 32'd1);
    rd(8'hFF, "R9 array mode after reset");
    cmd(8'h70);
    rd(8'hE0, "R9 status after reset");

    // R10: ID read
    cmd(8'h90); adr(8'h00);
    rd(8'hAD, "R10 maker code");
    rd(8'h76, "R10 device code");
    rd(8'h00, "R10 after id bytes");
    cmd(8'h70);
    cmd(8'h90); adr(8'h05);
    rd(8'hE0, "R10 nonzero id address");

    // R11: copy-back with and without confirm
    cmd(8'h00); adr4(32'h00000400);
    measure_busy(TR, "R11 source read");
    cmd(8'h8A); adr4(32'h00000420);
    measure_busy(TP, "R11 copy-back without confirm");
    check("R11 destination address", arr_addr, 32'h00000420);
    cmd(8'h70);
    rd(8'hE0, "R11 status without confirm");
    cmd(8'h8A); adr4(32'h00000440);
    cmd(8'h10);
    wait_ready(k);
    check("R11 confirm ends within program time", {31'd0, k < TP}, 32'd1);
    no_busy("R11 confirm starts nothing more");
    rd(8'hE0, "R11 status with confirm");

    repeat (5) @(negedge clk);
    check("R7 scoreboard drained", q_exp.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule